// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Shift Engine

This block moves one byte at a time over a four-wire serial peripheral bus. Each transfer is full duplex: eight bits leave on the serial output while eight bits arrive on the serial input. The most significant bit goes first. One configuration pin picks the role. As bus master, the block makes the serial clock from the system clock and drives its own select line. As slave, it follows a clock and a select line that another device drives. The slave brings those pins into its own clock domain through a two-stage synchronizer.

On the host side, bytes to send enter through a valid/ready port and received bytes leave through another. The transmit path has one buffer only. An accepted byte goes straight into the shift register, and `tx_ready` stays low for the whole transfer. A beat offered while `tx_ready` is low is not held for later. It is dropped, and the sticky write-collision flag is set. The receive path has two buffers. A finished byte moves into a holding register and stays there with `rx_valid` high until the host takes it with `rx_ready`, so the next transfer can already be running. A byte that finishes while the holding register is still full is thrown away, and the sticky overrun flag is set.

In master mode the serial clock always uses leading-edge sampling, whatever the phase pin says. The slave accepts both polarities and both phases.

Top module: `spi_dual_role`

## Requirements
- R1: A transfer shifts exactly 8 bits, MSB first, out on `sdo` while 8 bits are shifted in from `sdi`. The received byte appears on `rx_data` with its first-received bit in bit 7.
- R2: In master mode `ss_n_o` goes low on the clock edge that accepts a byte and stays low for 16×(`cfg_div`+1) cycles. `sclk_o` rests at `cfg_cpol` while idle, and each half period lasts `cfg_div`+1 system clocks. The first `sclk_o` change comes `cfg_div`+1 cycles after `ss_n_o` falls.
- R3: In master mode `cfg_cpha` is ignored. The master samples `sdi` on the edge that leaves the idle level and changes `sdo` on the edge that returns to it.
- R4: In slave mode all four combinations of `cfg_cpol`/`cfg_cpha` work. With `cfg_cpha`=0 the data is sampled on the leading edge. With `cfg_cpha`=1 it is sampled on the trailing edge, and `sdo` changes on every leading edge after the first.
- R5: In slave mode, while `ss_n_i` is high, `sdo_oe` is 0 and clock edges on `sclk_i` shift nothing and complete nothing.
- R6: `tx_ready` is low while a transfer is in progress. In slave mode that means while the slave is selected. A `tx_valid` beat offered while `tx_ready` is low is discarded, it does not change the byte being sent, and it sets `wr_collision`.
- R7: A completed byte is loaded into `rx_data` and `rx_valid` is raised, even while the next transfer is being prepared. `rx_valid` falls on an `rx_valid`&&`rx_ready` handshake.
- R8: If a byte completes while `rx_valid` is high and no handshake happens in that cycle, `overrun` is set and stays set, and `rx_data` keeps the older byte.
- R9: `xfer_done` is set when a byte completes and is cleared by the handshake that reads the receive port.
- R10: A one-cycle pulse on `flag_clr` clears `overrun` and `wr_collision`.
- R11: After reset `tx_ready`=1, `rx_valid`=0, all flags are 0, `ss_n_o`=1 and `sdo_oe`=0 in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Slave sample phase: 0 leading edge, 1 trailing edge |
| cfg_div | input | 4 | Master half-period length minus one, in system clocks |
| tx_valid | input | 1 | Host offers a byte to send |
| tx_ready | output | 1 | Engine can accept a byte |
| tx_data | input | 8 | Byte to send |
| rx_valid | output | 1 | Receive holding register is full |
| rx_ready | input | 1 | Host takes the received byte |
| rx_data | output | 8 | Received byte |
| xfer_done | output | 1 | A byte completed and has not yet been read |
| overrun | output | 1 | Sticky: a completed byte was lost |
| wr_collision | output | 1 | Sticky: a transmit beat was dropped |
| flag_clr | input | 1 | Clears the sticky flags |
| sclk_i | input | 1 | Serial clock from the master (slave role) |
| sclk_o | output | 1 | Generated serial clock (master role) |
| sclk_oe | output | 1 | Drive enable for `sclk_o` |
| ss_n_i | input | 1 | Select input, active low (slave role) |
| ss_n_o | output | 1 | Select output, active low (master role) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for `sdo` |

## Verification
In master mode the bench drives `tx_valid` for one cycle. It then counts system clocks on the falling edge of `clk`: `ss_n_o` falls at the accepting edge, `sclk_o` first moves `cfg_div`+1 cycles later, and `ss_n_o` rises after 16×(`cfg_div`+1) cycles. The bench's own slave model presents `sdi` bits on the trailing edges and reads `sdo` on the leading edges. `rx_valid`, `rx_data` and `xfer_done` are registered one cycle after the final sample, so the bench reads them one full cycle after `ss_n_o` rises. In slave mode each input passes through two synchronizer stages and one edge register, so `sdo` changes and samples take effect about three to four cycles after a pin edge. The bench therefore holds every `sclk_i` level for eight cycles and reads `sdo` just before the next edge it drives.

// File: rtl/spi_dr_pkg.sv
package spi_dr_pkg;
  localparam int unsigned BYTE_W = 8;

  // Level that marks the first clock edge of a bit cell
  function automatic logic lead_level(input logic cpol);
    return ~cpol;
  endfunction
endpackage

// File: rtl/spi_dr_sync.sv
module spi_dr_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
        else        chain <= {chain[STAGES-2:0], d[g]};
      end
      assign q[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/spi_dr_slave_front.sv
module spi_dr_slave_front #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpol,
  input  logic sclk_pin,
  input  logic ss_n_pin,
  input  logic sdi_pin,
  output logic sel,
  output logic lead_ev,
  output logic trail_ev,
  output logic sdi_s
);
  import spi_dr_pkg::*;
  localparam int unsigned NSIG = 3;

  logic [NSIG-1:0] raw, synced;
  logic            sclk_prev;
  logic            rise, fall;

  assign raw = {sdi_pin, ss_n_pin, sclk_pin};

  spi_dr_sync #(.WIDTH(NSIG), .STAGES(STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= synced[0];
  end

  assign rise     = synced[0] & ~sclk_prev;
  assign fall     = ~synced[0] & sclk_prev;
  assign sel      = ~synced[1];
  assign sdi_s    = synced[2];
  assign lead_ev  = sel & ((lead_level(cpol)) ? rise : fall);
  assign trail_ev = sel & ((lead_level(cpol)) ? fall : rise);
endmodule

// File: rtl/spi_dr_master_seq.sv
module spi_dr_master_seq #(
  parameter int unsigned DIV_W  = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cpol,
  input  logic [DIV_W-1:0] div,
  output logic             busy,
  output logic             sclk,
  output logic             samp_ev,
  output logic             shift_ev
);
  localparam int unsigned EDGES  = 2 * DATA_W;
  localparam int unsigned EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  logic [DIV_W-1:0]  tmr, div_l;
  logic [EDGE_W-1:0] edge_n;
  logic              sclk_q, cpol_l;
  logic              tick;

  assign tick     = busy && (tmr == '0);
  assign samp_ev  = tick && !edge_n[0];
  assign shift_ev = tick && edge_n[0];
  assign sclk     = busy ? sclk_q : cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      tmr    <= '0;
      div_l  <= '0;
      edge_n <= '0;
      sclk_q <= 1'b0;
      cpol_l <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        tmr    <= div;
        div_l  <= div;
        edge_n <= '0;
        sclk_q <= cpol;
        cpol_l <= cpol;
      end
    end else if (tick) begin
      tmr    <= div_l;
      sclk_q <= ~sclk_q;
      edge_n <= edge_n + 1'b1;
      if (edge_n == LAST_EDGE) begin
        busy   <= 1'b0;
        sclk_q <= cpol_l;
      end
    end else begin
      tmr <= tmr - 1'b1;
    end
  end
endmodule

// File: rtl/spi_dr_rxbuf.sv
module spi_dr_rxbuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmpl,
  input  logic [DATA_W-1:0] cmpl_data,
  input  logic              rx_ready,
  input  logic              flag_clr,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              overrun,
  output logic              done
);
  logic pop;
  assign pop = rx_valid && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      overrun  <= 1'b0;
      done     <= 1'b0;
    end else begin
      if (flag_clr) overrun <= 1'b0;
      if (cmpl) begin
        done <= 1'b1;
        if (rx_valid && !pop) begin
          overrun <= 1'b1;
        end else begin
          rx_data  <= cmpl_data;
          rx_valid <= 1'b1;
        end
      end else if (pop) begin
        rx_valid <= 1'b0;
        done     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_dual_role.sv
module spi_dual_role #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned DIV_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              xfer_done,
  output logic              overrun,
  output logic              wr_collision,
  input  logic              flag_clr,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe,
  input  logic              ss_n_i,
  output logic              ss_n_o,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int unsigned CNT_W = $clog2(DATA_W) + 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              m_busy, m_sclk, m_samp, m_shift;
  logic              s_sel, s_lead, s_trail, s_sdi;
  logic              samp_ev, shift_ev, samp_bit;
  logic              tx_fire, cmpl;
  logic [DATA_W-1:0] tx_sh, rx_sh, cmpl_data;
  logic [CNT_W-1:0]  bit_cnt;

  spi_dr_master_seq #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_mseq (
    .clk(clk), .rst_n(rst_n), .start(tx_fire && cfg_master),
    .cpol(cfg_cpol), .div(cfg_div), .busy(m_busy), .sclk(m_sclk),
    .samp_ev(m_samp), .shift_ev(m_shift)
  );

  spi_dr_slave_front #(.STAGES(SYNC_STAGES)) u_sfront (
    .clk(clk), .rst_n(rst_n), .cpol(cfg_cpol), .sclk_pin(sclk_i),
    .ss_n_pin(ss_n_i), .sdi_pin(sdi), .sel(s_sel), .lead_ev(s_lead),
    .trail_ev(s_trail), .sdi_s(s_sdi)
  );

  // Role selection: the master timing never uses the phase pin
  always_comb begin
    if (cfg_master) begin
      samp_ev  = m_samp;
      shift_ev = m_shift;
      samp_bit = sdi;
    end else begin
      samp_ev  = cfg_cpha ? s_trail : s_lead;
      shift_ev = cfg_cpha ? (s_lead && bit_cnt != '0) : s_trail;
      samp_bit = s_sdi;
    end
  end

  assign tx_ready  = cfg_master ? !m_busy : !s_sel;
  assign tx_fire   = tx_valid && tx_ready;
  assign cmpl      = samp_ev && (bit_cnt == LAST_BIT);
  assign cmpl_data = {rx_sh[DATA_W-2:0], samp_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh        <= '0;
      rx_sh        <= '0;
      bit_cnt      <= '0;
      wr_collision <= 1'b0;
    end else begin
      if (flag_clr) wr_collision <= 1'b0;
      if (tx_valid && !tx_ready) wr_collision <= 1'b1;

      if (tx_fire) begin
        tx_sh   <= tx_data;
        bit_cnt <= '0;
      end else if (!cfg_master && !s_sel) begin
        bit_cnt <= '0;
      end else begin
        if (shift_ev) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        if (samp_ev) begin
          rx_sh   <= cmpl_data;
          bit_cnt <= cmpl ? '0 : bit_cnt + 1'b1;
        end
      end
    end
  end

  spi_dr_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
    .clk(clk), .rst_n(rst_n), .cmpl(cmpl), .cmpl_data(cmpl_data),
    .rx_ready(rx_ready), .flag_clr(flag_clr), .rx_valid(rx_valid),
    .rx_data(rx_data), .overrun(overrun), .done(xfer_done)
  );

  assign sdo     = tx_sh[DATA_W-1];
  assign sdo_oe  = cfg_master | ~ss_n_i;
  assign sclk_o  = m_sclk;
  assign sclk_oe = cfg_master;
  assign ss_n_o  = !(cfg_master && m_busy);
endmodule

// File: rtl/spi_dual_role_chk.sv
module spi_dual_role_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_master,
  input logic              cfg_cpol,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              xfer_done,
  input logic              overrun,
  input logic              wr_collision,
  input logic              flag_clr,
  input logic              ss_n_i,
  input logic              ss_n_o,
  input logic              sclk_o,
  input logic              sdo_oe,
  input logic              cmpl
);
  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && ss_n_o |-> sclk_o == cfg_cpol);

  p_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master && ss_n_i |-> !sdo_oe);

  p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && !ss_n_o |-> !tx_ready);

  p_wcol_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> wr_collision);

  p_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(cmpl));

  p_keep_old_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !flag_clr |=> overrun);

  p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && !cmpl |=> !xfer_done);
endmodule

bind spi_dual_role spi_dual_role_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data), .xfer_done(xfer_done),
  .overrun(overrun), .wr_collision(wr_collision), .flag_clr(flag_clr),
  .ss_n_i(ss_n_i), .ss_n_o(ss_n_o), .sclk_o(sclk_o), .sdo_oe(sdo_oe),
  .cmpl(cmpl)
);

// File: tb/spi_dual_role_bench.sv
module spi_dual_role_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cfg_master = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [3:0] cfg_div = '0;
  logic       tx_valid = 1'b0, rx_ready = 1'b0, flag_clr = 1'b0;
  logic [7:0] tx_data = '0;
  logic       sclk_i = 1'b0, ss_n_i = 1'b1, s_sdi = 1'b0, m_sdi = 1'b0;
  logic       tx_ready, rx_valid, xfer_done, overrun, wr_collision;
  logic [7:0] rx_data;
  logic       sclk_o, sclk_oe, ss_n_o, sdo, sdo_oe, sdi;

  int n_chk = 0, n_fail = 0, cyc = 0;

  assign sdi = cfg_master ? m_sdi : s_sdi;

  spi_dual_role u_spi_dual_role (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_div(cfg_div), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .xfer_done(xfer_done),
    .overrun(overrun), .wr_collision(wr_collision), .flag_clr(flag_clr),
    .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe), .ss_n_i(ss_n_i),
    .ss_n_o(ss_n_o), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bench-side slave model for master-mode transfers
  logic [7:0] m_pat = '0, mon = '0;
  logic       prev_ss = 1'b1, prev_sclk = 1'b0, first_seen = 1'b0;
  int         idx = 0, half_cnt = 0, low_cnt = 0, meas = 0;

  always @(negedge clk) begin
    cyc++;
    if (cfg_master) begin
      if (prev_ss && !ss_n_o) begin
        m_sdi = m_pat[7]; idx = 6; half_cnt = 0; low_cnt = 1;
        first_seen = 1'b0; mon = '0;
      end else if (!ss_n_o) begin
        low_cnt++;
        if (!first_seen) half_cnt++;
        if (sclk_o != prev_sclk) begin
          if (!first_seen) begin first_seen = 1'b1; meas = half_cnt; end
          if (sclk_o != cfg_cpol) mon = {mon[6:0], sdo};
          else if (idx >= 0) begin m_sdi = m_pat[idx]; idx--; end
        end
      end
    end
    prev_ss   = ss_n_o;
    prev_sclk = sclk_o;
  end

  task automatic pop_rx();
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic master_xfer(input logic [7:0] din, input logic [7:0] pat,
                             input logic [3:0] dv, input logic pol,
                             input logic pha, input bit coll);
    cfg_master = 1'b1; cfg_cpol = pol; cfg_cpha = pha; cfg_div = dv;
    m_pat = pat;
    @(negedge clk);
    chk(sclk_o == pol, "R2", "idle sclk level", sclk_o, pol);
    tx_data = din; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    if (coll) begin
      repeat (3) @(negedge clk);
      chk(tx_ready == 1'b0, "R6", "tx_ready during transfer", tx_ready, 0);
      tx_data = ~din; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      chk(wr_collision == 1'b1, "R6", "collision flag", wr_collision, 1);
    end
    while (!ss_n_o) @(negedge clk);
    @(negedge clk);
    chk(meas == int'(dv) + 1, pha ? "R3" : "R2", "first half period", meas, dv + 1);
    chk(low_cnt == 16 * (int'(dv) + 1), "R2", "select low cycles", low_cnt, 16 * (dv + 1));
    chk(mon == din, "R1", "master sdo byte", mon, din);
    chk(rx_data == pat && rx_valid, pha ? "R3" : "R1", "master rx byte", rx_data, pat);
    chk(xfer_done == 1'b1, "R9", "done after master byte", xfer_done, 1);
  endtask

  // Bench acts as the external master for slave-mode transfers
  task automatic slave_bits(input logic [7:0] mbyte, input logic pol,
                            input logic pha, output logic [7:0] got);
    got = '0;
    for (int i = 7; i >= 0; i--) begin
      if (!pha) begin
        s_sdi = mbyte[i];
        repeat (HALF) @(negedge clk);
        got = {got[6:0], sdo};
        sclk_i = ~pol;
        repeat (HALF) @(negedge clk);
        sclk_i = pol;
      end else begin
        sclk_i = ~pol;
        s_sdi = mbyte[i];
        repeat (HALF) @(negedge clk);
        got = {got[6:0], sdo};
        sclk_i = pol;
        repeat (HALF) @(negedge clk);
      end
    end
  endtask

  task automatic slave_xfer(input logic [7:0] din, input logic [7:0] mbyte,
                            input logic pol, input logic pha, input bit load,
                            output logic [7:0] got);
    cfg_master = 1'b0; cfg_cpol = pol; cfg_cpha = pha; sclk_i = pol;
    repeat (4) @(negedge clk);
    if (load) begin
      tx_data = din; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
    end
    ss_n_i = 1'b0;
    repeat (HALF) @(negedge clk);
    slave_bits(mbyte, pol, pha, got);
    repeat (HALF) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  logic [7:0] got, d0, d1;
  logic       p0, p1;
  logic [3:0] dv;

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R11", "reset tx_ready", tx_ready, 1);
    chk(rx_valid == 1'b0, "R11", "reset rx_valid", rx_valid, 0);
    chk({xfer_done, overrun, wr_collision} == 3'b000, "R11", "reset flags",
        {xfer_done, overrun, wr_collision}, 0);
    chk(ss_n_o == 1'b1 && sdo_oe == 1'b0, "R11", "reset select/oe",
        {ss_n_o, sdo_oe}, 2);

    // Directed master cases
    master_xfer(8'hA5, 8'h3C, 4'd0, 1'b0, 1'b0, 1'b0); pop_rx();
    master_xfer(8'h81, 8'h7E, 4'd3, 1'b1, 1'b0, 1'b0); pop_rx();
    master_xfer(8'h5A, 8'hC3, 4'd2, 1'b0, 1'b1, 1'b0); pop_rx();   // R3
    master_xfer(8'h96, 8'h69, 4'd1, 1'b1, 1'b1, 1'b1); pop_rx();   // R6 collision
    chk(xfer_done == 1'b0, "R9", "done cleared by read", xfer_done, 0);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk(wr_collision == 1'b0, "R10", "collision cleared", wr_collision, 0);

    // R7: second transfer runs with first byte still held; read during it
    master_xfer(8'h11, 8'h22, 4'd1, 1'b0, 1'b0, 1'b0);
    cfg_master = 1'b1;
    tx_data = 8'h33; m_pat = 8'h44; tx_valid = 1'b1; @(negedge clk); tx_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(rx_data == 8'h22 && rx_valid, "R7", "first byte held during next", rx_data, 8'h22);
    pop_rx();
    while (!ss_n_o) @(negedge clk);
    @(negedge clk);
    chk(rx_data == 8'h44 && rx_valid, "R7", "second byte loaded", rx_data, 8'h44);
    chk(overrun == 1'b0, "R7", "no overrun when read in time", overrun, 0);
    pop_rx();

    // Random master transfers
    for (int k = 0; k < 16; k++) begin
      d0 = 8'($urandom); d1 = 8'($urandom); dv = 4'($urandom_range(0, 3));
      p0 = 1'($urandom); p1 = 1'($urandom);
      master_xfer(d0, d1, dv, p0, p1, 1'b0); pop_rx();
    end

    // R5: deselected slave ignores its clock
    cfg_master = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    repeat (4) @(negedge clk);
    chk(sdo_oe == 1'b0, "R5", "sdo_oe while deselected", sdo_oe, 0);
    for (int i = 0; i < 10; i++) begin
      sclk_i = ~sclk_i; repeat (HALF) @(negedge clk);
    end
    sclk_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(rx_valid == 1'b0 && xfer_done == 1'b0, "R5", "no completion while deselected",
        rx_valid, 0);

    // R4: all four slave modes, directed
    for (int m = 0; m < 4; m++) begin
      d0 = 8'hC5 ^ 8'(m * 17); d1 = 8'h39 ^ 8'(m * 29);
      slave_xfer(d0, d1, m[1], m[0], 1'b1, got);
      chk(got == d0, "R4", "slave sdo byte", got, d0);
      chk(rx_data == d1 && rx_valid, "R4", "slave rx byte", rx_data, d1);
      pop_rx();
    end

    // R6 in slave mode: write while selected is dropped
    cfg_master = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0; sclk_i = 1'b0;
    tx_data = 8'hF0; tx_valid = 1'b1; @(negedge clk); tx_valid = 1'b0;
    ss_n_i = 1'b0; repeat (HALF) @(negedge clk);
    chk(sdo_oe == 1'b1, "R5", "sdo_oe while selected", sdo_oe, 1);
    tx_data = 8'h0F; tx_valid = 1'b1; @(negedge clk); tx_valid = 1'b0;
    chk(wr_collision == 1'b1, "R6", "slave collision flag", wr_collision, 1);
    slave_bits(8'h5C, 1'b0, 1'b0, got);
    repeat (HALF) @(negedge clk); ss_n_i = 1'b1; repeat (6) @(negedge clk);
    chk(got == 8'hF0, "R6", "dropped beat left byte intact", got, 8'hF0);

    // R8: overrun keeps older byte
    slave_xfer(8'h00, 8'hB7, 1'b1, 1'b1, 1'b1, got);
    chk(rx_data == 8'h5C, "R8", "older byte kept", rx_data, 8'h5C);
    chk(overrun == 1'b1, "R8", "overrun set", overrun, 1);
    repeat (3) @(negedge clk);
    chk(overrun == 1'b1, "R8", "overrun sticky", overrun, 1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk(overrun == 1'b0 && wr_collision == 1'b0, "R10", "flags cleared",
        {overrun, wr_collision}, 0);
    pop_rx();

    // Random slave transfers
    for (int k = 0; k < 12; k++) begin
      d0 = 8'($urandom); d1 = 8'($urandom); p0 = 1'($urandom); p1 = 1'($urandom);
      slave_xfer(d0, d1, p0, p1, 1'b1, got);
      chk(got == d0, "R4", "random slave sdo", got, d0);
      chk(rx_data == d1, "R1", "random slave rx", rx_data, d1);
      pop_rx();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= WATCHDOG);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected < %0d", cyc, WATCHDOG);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule